// File: doc/BRIEF.md
# Descriptor Ring Index Manager

This block keeps track of where a controller stands in a ring of buffer descriptors held in host memory. One instance serves one ring, so a transmit ring and a receive ring each get their own instance with their own configuration. The ring is set up by a single 32-bit pointer word. Its top three bits give the ring size as a power of two. Bits 23 to 3 give a base address that is always aligned to 8 bytes. A separate disable flag, loaded together with the word, keeps the ring from being touched at all.

On a kick, the block reads the first word of the current descriptor over a simple request/acknowledge port. Bit 31 of that word is the ownership flag. When it is set, the controller may use the descriptor: the block pulses a transfer-start strobe and presents the 24-bit buffer pointer held in bits 23..0. When it is clear, the block raises a stall flag and waits for the next kick to poll the same descriptor again. Once the surrounding logic reports that the buffer is done, the block writes the word back with the ownership flag cleared, handing the descriptor back to the host. It then moves to the next entry, wrapping to index 0 after the last one.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset the block issues no memory request, the stall flag and the transfer strobe are low, the ring index is 0, and the ring is disabled until a configuration load.
- R2: A configuration load sets the ring base to the pointer word's bits 23..3 followed by three zero bits. Pointer bits 2..0 and 28..24 have no effect on any descriptor address.
- R3: The pointer word's bits 31..29 hold a code c, and the ring holds 2^c entries. After the entry with index 2^c-1 is finished, the index becomes 0 again.
- R4: The descriptor address is (base + index*8) modulo 2^24, so every request address has its low three bits at zero.
- R5: A kick while idle issues one read of the current descriptor. If bit 31 of the returned word is 1, xfer_start pulses for one cycle, in the cycle after the acknowledge, and xfer_buf_ptr carries bits 23..0 of that word.
- R6: If bit 31 of the returned word is 0, ring_stall rises, no transfer starts and the index is unchanged. No further read happens until the next kick, which reads the same address again.
- R7: While the ring is disabled, a kick causes no memory request.
- R8: After buf_done, the block writes to the address of the descriptor just used. The written word is the word read before, with bit 31 cleared and all other bits kept. After the write is acknowledged, the index advances by one.
- R9: A configuration load is accepted only while idle or stalled, and it resets the index to 0. A load during a transfer or a memory access is ignored.
- R10: Once raised, a memory request holds its address and direction unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load cfg_ptr and cfg_disable |
| cfg_ptr | input | 32 | Ring pointer word (size code 31..29, base 23..3) |
| cfg_disable | input | 1 | Ring disabled when loaded as 1 |
| kick | input | 1 | Start or retry a descriptor fetch |
| buf_done | input | 1 | Current buffer finished |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 24 | Descriptor byte address |
| mem_wdata | output | 32 | Write-back word |
| mem_rdata | input | 32 | Read word, valid with mem_ack |
| mem_ack | input | 1 | Request acknowledge |
| xfer_start | output | 1 | One-cycle start of a buffer transfer |
| xfer_buf_ptr | output | 24 | Buffer pointer from the owned descriptor |
| ring_stall | output | 1 | Current descriptor not owned by controller |
| ring_idx | output | 7 | Current ring index |

## Verification
Some properties are checked by assertions on every cycle. A disabled ring never requests memory. Request addresses stay 8-byte aligned and the index stays inside the configured ring. A request stays stable until it is acknowledged. A transfer starts only after an owned word was read, and a stall only after an unowned one. Write-backs never carry the ownership flag, and every acknowledged write-back moves the index. Other behaviour only the bench scenarios can show. These are the exact address sequence for each size code, including the wrap back to the base and the 24-bit address wrap. They also cover the buffer pointer and the write-back word values, the repeated poll of one stalled descriptor, and a configuration load that is ignored during a transfer.

// File: rtl/ring_pkg.sv
package ring_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_READ  = 3'd1,
    S_BUSY  = 3'd2,
    S_WBACK = 3'd3,
    S_STALL = 3'd4
  } walk_state_t;

  // number of entries selected by a power-of-two size code
  function automatic int unsigned ring_entries(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // byte offset of a descriptor inside the ring
  function automatic int unsigned desc_offset(input int unsigned idx,
                                              input int unsigned shift);
    return idx << shift;
  endfunction

endpackage

// File: rtl/ring_ptr_decode.sv
module ring_ptr_decode #(
  parameter int PTR_W   = 32,
  parameter int ADDR_W  = 24,
  parameter int CODE_W  = 3,
  parameter int ALIGN_W = 3
) (
  input  logic [PTR_W-1:0]  ptr,
  output logic [ADDR_W-1:0] base_o,
  output logic [CODE_W-1:0] code_o
);
  logic unused_bits;

  assign base_o      = {ptr[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign code_o      = ptr[PTR_W-1 -: CODE_W];
  assign unused_bits = ^{ptr[PTR_W-CODE_W-1:ADDR_W], ptr[ALIGN_W-1:0]};
endmodule

// File: rtl/ring_index_ctr.sv
module ring_index_ctr #(
  parameter int CODE_W = 3,
  localparam int IDX_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [CODE_W-1:0] code,
  output logic [IDX_W-1:0]  idx,
  output logic [IDX_W-1:0]  mask
);
  logic [IDX_W-1:0] idx_next;

  assign mask     = IDX_W'(ring_pkg::ring_entries(32'(code)) - 32'd1);
  assign idx_next = (idx + IDX_W'(1)) & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= idx_next;
  end
endmodule

// File: rtl/ring_owner_fsm.sv
module ring_owner_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic buf_done,
  input  logic dis,
  input  logic cfg_take,
  input  logic mem_ack,
  input  logic own_bit,
  output logic mem_req,
  output logic mem_we,
  output logic rd_hit,
  output logic wb_done,
  output logic xfer_start,
  output logic stall,
  output logic cfg_ok
);
  import ring_pkg::*;

  walk_state_t state, state_nx;

  assign mem_req = (state == S_READ) || (state == S_WBACK);
  assign mem_we  = (state == S_WBACK);
  assign rd_hit  = (state == S_READ) && mem_ack;
  assign wb_done = (state == S_WBACK) && mem_ack;
  assign stall   = (state == S_STALL);
  assign cfg_ok  = (state == S_IDLE) || (state == S_STALL);

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE, S_STALL: begin
        if (cfg_take)         state_nx = S_IDLE;
        else if (kick && !dis) state_nx = S_READ;
      end
      S_READ:  if (mem_ack) state_nx = own_bit ? S_BUSY : S_STALL;
      S_BUSY:  if (buf_done) state_nx = S_WBACK;
      S_WBACK: if (mem_ack) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      xfer_start <= 1'b0;
    end else begin
      state      <= state_nx;
      xfer_start <= rd_hit && own_bit;
    end
  end
endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int CODE_W  = 3,
  parameter int ALIGN_W = 3,
  parameter int OWN_BIT = 31,
  localparam int IDX_W  = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [DATA_W-1:0] cfg_ptr,
  input  logic              cfg_disable,
  input  logic              kick,
  input  logic              buf_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              xfer_start,
  output logic [ADDR_W-1:0] xfer_buf_ptr,
  output logic              ring_stall,
  output logic [IDX_W-1:0]  ring_idx
);
  // named internal events, also used by the bound checker
  logic [ADDR_W-1:0] dec_base, base_q;
  logic [CODE_W-1:0] dec_code, code_q;
  logic              dis_q;
  logic [IDX_W-1:0]  idx_mask;
  logic [DATA_W-1:0] word_q;
  logic              cfg_ok, cfg_take, rd_hit, wb_done;

  ring_ptr_decode #(.PTR_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
                    .ALIGN_W(ALIGN_W)) u_dec (
    .ptr(cfg_ptr), .base_o(dec_base), .code_o(dec_code));

  assign cfg_take = cfg_load && cfg_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      code_q <= '0;
      dis_q  <= 1'b1;
    end else if (cfg_take) begin
      base_q <= dec_base;
      code_q <= dec_code;
      dis_q  <= cfg_disable;
    end
  end

  ring_index_ctr #(.CODE_W(CODE_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(cfg_take), .adv(wb_done),
    .code(code_q), .idx(ring_idx), .mask(idx_mask));

  ring_owner_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .kick(kick), .buf_done(buf_done),
    .dis(dis_q), .cfg_take(cfg_take), .mem_ack(mem_ack),
    .own_bit(mem_rdata[OWN_BIT]), .mem_req(mem_req), .mem_we(mem_we),
    .rd_hit(rd_hit), .wb_done(wb_done), .xfer_start(xfer_start),
    .stall(ring_stall), .cfg_ok(cfg_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (rd_hit) word_q <= mem_rdata;
  end

  assign mem_addr     = base_q + ADDR_W'(ring_pkg::desc_offset(32'(ring_idx), ALIGN_W));
  assign mem_wdata    = word_q & ~(DATA_W'(1) << OWN_BIT);
  assign xfer_buf_ptr = word_q[ADDR_W-1:0];
endmodule

// File: rtl/ring_walker_chk.sv
module ring_walker_chk #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int ALIGN_W = 3,
  parameter int OWN_BIT = 31,
  parameter int IDX_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              xfer_start,
  input logic              ring_stall,
  input logic [IDX_W-1:0]  ring_idx,
  input logic [IDX_W-1:0]  idx_mask,
  input logic              dis_q,
  input logic              rd_hit,
  input logic              wb_done
);
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> !mem_req);

  p_addr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[ALIGN_W-1:0] == '0));

  p_idx_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_idx & ~idx_mask) == '0);

  p_start_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(rd_hit && mem_rdata[OWN_BIT]));

  p_stall_unowned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_stall) |-> $past(rd_hit && !mem_rdata[OWN_BIT]));

  p_wb_hands_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

  p_wb_advances_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> ((ring_idx != $past(ring_idx)) || (idx_mask == '0)));

  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind desc_ring_walker ring_walker_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALIGN_W(ALIGN_W),
  .OWN_BIT(OWN_BIT), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata), .xfer_start(xfer_start), .ring_stall(ring_stall),
  .ring_idx(ring_idx), .idx_mask(idx_mask), .dis_q(dis_q),
  .rd_hit(rd_hit), .wb_done(wb_done));

// File: tb/tb_desc_ring_walker.sv
module tb_desc_ring_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load, cfg_disable, kick, buf_done;
  logic [31:0] cfg_ptr;
  logic        mem_req, mem_we, mem_ack;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        xfer_start, ring_stall;
  logic [23:0] xfer_buf_ptr;
  logic [6:0]  ring_idx;

  always #5 clk = ~clk;

  desc_ring_walker dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ptr(cfg_ptr),
    .cfg_disable(cfg_disable), .kick(kick), .buf_done(buf_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .xfer_start(xfer_start), .xfer_buf_ptr(xfer_buf_ptr),
    .ring_stall(ring_stall), .ring_idx(ring_idx));

  // host memory model: descriptor words indexed by address bits 10..3
  logic [31:0] mem [256];
  int          rd_cnt = 0, wr_cnt = 0, ack_delay = 0, wait_cnt = 0, addr_moved = 0;
  logic [23:0] last_rd_addr = '0, last_wr_addr = '0, req_addr0 = '0;
  logic [31:0] last_wr_data = '0;
  int          checks = 0, failures = 0;

  initial mem_ack = 1'b0;
  initial mem_rdata = '0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_cnt == 0) req_addr0 <= mem_addr;
      else if (mem_addr != req_addr0) addr_moved <= addr_moved + 1;
      if (wait_cnt >= ack_delay) begin
        mem_ack  <= 1'b1;
        wait_cnt <= 0;
        if (mem_we) begin
          wr_cnt       <= wr_cnt + 1;
          last_wr_addr <= mem_addr;
          last_wr_data <= mem_wdata;
        end else begin
          rd_cnt       <= rd_cnt + 1;
          last_rd_addr <= mem_addr;
          mem_rdata    <= mem[mem_addr[10:3]];
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  // rows: pointer words covering every size-code class
  localparam logic [31:0] RING_TAB [5] = '{
    32'h0000_0105,   // code 0, base 0x100, junk low bits
    32'h5F00_0200,   // code 2, base 0x200, reserved bits set
    32'h6000_0400,   // code 3, base 0x400
    32'h20FF_FFF8,   // code 1, base 0xFFFFF8, 24-bit wrap
    32'hE000_0000    // code 7, base 0
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int k = 0; k < 256; k++) mem[k] = 32'h8000_0000 | 32'(k * 16 + 3);
  endtask

  task automatic load_cfg(input logic [31:0] p, input logic d);
    @(negedge clk); cfg_ptr = p; cfg_disable = d; cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic do_kick(output bit st, output bit sl);
    st = 0; sl = 0;
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    for (int n = 0; n < 30 && !st && !sl; n++) begin
      @(negedge clk);
      if (xfer_start) st = 1;
      if (ring_stall) sl = 1;
    end
  endtask

  task automatic do_finish();
    int w0;
    w0 = wr_cnt;
    @(negedge clk); buf_done = 1'b1;
    @(negedge clk); buf_done = 1'b0;
    for (int n = 0; n < 30 && wr_cnt == w0; n++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit st, sl;
    int r0;
    rst_n = 1'b0; cfg_load = 1'b0; cfg_disable = 1'b0; kick = 1'b0;
    buf_done = 1'b0; cfg_ptr = '0;
    fill_mem();
    repeat (3) @(negedge clk);
    chk(!mem_req,   "R1 mem_req low", 32'(mem_req), 0);
    chk(!ring_stall && !xfer_start, "R1 flags low", 32'({ring_stall, xfer_start}), 0);
    chk(ring_idx == 0, "R1 index zero", 32'(ring_idx), 0);
    rst_n = 1'b1;

    // R1/R7: disabled out of reset, kick ignored
    do_kick(st, sl);
    chk(rd_cnt == 0 && !st, "R7 kick after reset no access", 32'(rd_cnt), 0);
    load_cfg(32'h6000_0400, 1'b1);
    do_kick(st, sl);
    chk(rd_cnt == 0 && !mem_req, "R7 disabled ring no access", 32'(rd_cnt), 0);

    // table walk: every entry of each ring plus one wrap
    foreach (RING_TAB[r]) begin
      logic [23:0] base, exp_addr;
      int ents;
      base = {RING_TAB[r][23:3], 3'b000};
      ents = 1 << RING_TAB[r][31:29];
      fill_mem();
      load_cfg(RING_TAB[r], 1'b0);
      chk(ring_idx == 0, "R9 load resets index", 32'(ring_idx), 0);
      for (int i = 0; i <= ents; i++) begin
        exp_addr = base + 24'((i % ents) * 8);
        do_kick(st, sl);
        chk(st && !sl, "R5 owned descriptor starts transfer", 32'({st, sl}), 32'h2);
        if (i == 0)
          chk(last_rd_addr == exp_addr, "R2 first address from pointer", 32'(last_rd_addr), 32'(exp_addr));
        else if (i == ents)
          chk(last_rd_addr == exp_addr, "R3 wrap to base", 32'(last_rd_addr), 32'(exp_addr));
        else
          chk(last_rd_addr == exp_addr, "R4 descriptor address", 32'(last_rd_addr), 32'(exp_addr));
        chk(xfer_buf_ptr == mem[exp_addr[10:3]][23:0], "R5 buffer pointer",
            32'(xfer_buf_ptr), 32'(mem[exp_addr[10:3]][23:0]));
        do_finish();
        chk(last_wr_addr == exp_addr, "R8 write-back address", 32'(last_wr_addr), 32'(exp_addr));
        chk(last_wr_data == {1'b0, mem[exp_addr[10:3]][30:0]}, "R8 write-back word",
            last_wr_data, {1'b0, mem[exp_addr[10:3]][30:0]});
        chk(ring_idx == 7'((i + 1) % ents), "R3 index advance and wrap",
            32'(ring_idx), 32'((i + 1) % ents));
      end
    end

    // R6: unowned descriptor stalls, polls again only on kick
    fill_mem();
    load_cfg(32'h4000_0200, 1'b0);
    mem[64] = 32'h0000_0123;
    do_kick(st, sl);
    chk(sl && !st, "R6 stall on unowned", 32'({st, sl}), 32'h1);
    chk(ring_idx == 0, "R6 index held on stall", 32'(ring_idx), 0);
    r0 = rd_cnt;
    repeat (6) @(negedge clk);
    chk(rd_cnt == r0 && ring_stall, "R6 no poll without kick", 32'(rd_cnt - r0), 0);
    mem[64] = 32'h8000_0456;
    do_kick(st, sl);
    chk(st && last_rd_addr == 24'h000200, "R6 repoll same descriptor", 32'(last_rd_addr), 32'h200);
    chk(!ring_stall, "R6 stall cleared", 32'(ring_stall), 0);
    do_finish();
    chk(ring_idx == 1, "R8 index after stall recovery", 32'(ring_idx), 1);

    // R9: load during a transfer ignored, load while idle accepted
    do_kick(st, sl);
    chk(last_rd_addr == 24'h000208, "R4 second entry address", 32'(last_rd_addr), 32'h208);
    load_cfg(32'h0000_0100, 1'b0);
    do_finish();
    do_kick(st, sl);
    chk(last_rd_addr == 24'h000210, "R9 load during transfer ignored", 32'(last_rd_addr), 32'h210);
    do_finish();
    load_cfg(32'h0000_0100, 1'b0);
    do_kick(st, sl);
    chk(last_rd_addr == 24'h000100, "R9 load while idle accepted", 32'(last_rd_addr), 32'h100);
    do_finish();

    // R10: slow acknowledge, request must hold
    ack_delay = 3;
    load_cfg(32'h6000_0400, 1'b0);
    do_kick(st, sl);
    chk(st && last_rd_addr == 24'h000400, "R10 slow read completes", 32'(last_rd_addr), 32'h400);
    do_finish();
    chk(last_wr_addr == 24'h000400, "R10 slow write completes", 32'(last_wr_addr), 32'h400);
    chk(addr_moved == 0, "R10 address held until ack", 32'(addr_moved), 0);
    ack_delay = 0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule